// File: doc/BRIEF.md
# Five-Stage Load/Store Pipeline Core

This block is a small in-order processor core that moves each instruction through five stages in a fixed sequence: fetch, decode with register read, execute (or address calculation), data memory access, and register write-back. A register separates each pair of neighbouring stages. Decode turns the instruction word into a handful of control bits once. Each later register keeps only the bits its downstream stages still use. The destination register index travels with the instruction all the way to write-back. The core runs a 32-bit subset with four register-register operations (add, subtract, and, or), a word load and a word store. It has no hazard detection, no forwarding beyond the register file, and no branches. Programs must therefore keep dependent instructions at least three slots apart.

Instruction and data memory are synchronous arrays inside the core. A host fills them while the `run` input is low, then raises `run`. While `run` is high the core fetches one instruction per cycle, starting at address 0 after reset. The retire outputs report every instruction as it leaves write-back. The host reads the result of a program through a register-file read port and the data-memory port.

Top module: `pipe5_core`

## Requirements
- R1: After reset, the instruction fetched on the first rising edge with `run` high retires on the fifth rising edge. `ret_valid` is high in the cycle after that edge. No instruction retires in the first four cycles after reset.
- R2: The fetch address is 0 after reset and grows by 4 on every edge where `run` is high. `ret_pc4` reports the fetch address of the retiring instruction plus 4. Instructions already in flight keep draining after `run` falls.
- R3: Every edge with `run` high produces exactly one retirement four edges later. Holding `run` high for N edges gives N consecutive cycles with `ret_valid` high.
- R4: Register-register operations use opcode bits[31:26]=0x00, sources rs=bits[25:21] and rt=bits[20:16], and destination rd=bits[15:11]. The function field bits[5:0] selects add (0x20), subtract (0x22, rs minus rt), and (0x24) or or (0x25).
- R5: A load (opcode 0x23) writes rt=bits[20:16] with the data word at byte address rs + sign-extended bits[15:0]. `ret_we` is 1 and `ret_data` is the loaded value.
- R6: A store (opcode 0x2B) writes rt's value to the data word at byte address rs + sign-extended bits[15:0], including negative offsets. It retires with `ret_we` 0.
- R7: Register 0 always reads as zero. A write to it is reported on the retire outputs but changes nothing.
- R8: A value written back is seen by an instruction that reads it three slots later, in the same cycle as the write.
- R9: Synchronous reset clears the fetch address and every in-flight instruction. No memory or register write takes effect on an edge where reset is high. Nothing retires after reset until new instructions are fetched.
- R10: A load or store whose byte address is not word aligned, or lies beyond the data memory (2^DAW words), does not touch memory. Such a load returns zero.
- R11: An encoding outside the supported set, including the all-zero word, retires as a no-op with `ret_we` 0 and writes nothing.
- R12: When no instruction is in the memory stage, the data port (`dm_we`, `dm_addr`, `dm_wdata`) writes and reads data memory by word index, with `dm_rdata` valid one cycle after the address. `im_we` writes instruction memory by word index. `reg_rdata` shows register `reg_raddr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Fetch one instruction per cycle while high |
| im_we | input | 1 | Instruction memory write strobe |
| im_waddr | input | IAW | Instruction memory word index |
| im_wdata | input | 32 | Instruction word to store |
| dm_we | input | 1 | Host data memory write strobe |
| dm_addr | input | DAW | Host data memory word index |
| dm_wdata | input | 32 | Host data word to store |
| dm_rdata | output | 32 | Data memory read word, one cycle after address |
| reg_raddr | input | 5 | Host register read index |
| reg_rdata | output | 32 | Register value, one cycle after index |
| ret_valid | output | 1 | An instruction left write-back on the last edge |
| ret_we | output | 1 | The retired instruction names a destination register |
| ret_idx | output | 5 | Destination register of the retired instruction |
| ret_data | output | 32 | Value written by the retired instruction |
| ret_pc4 | output | 32 | Fetch address plus 4 of the retired instruction |

## Verification
The main program mixes loads and stores that use positive and negative offsets with all four register operations. It also contains a write aimed at register 0, a store beyond the memory, a misaligned load and a no-op. Operands sit four or five slots behind their producers, and one sits exactly three slots behind, which separates a working same-cycle register bypass from a missing one. Every cycle of the run, the retire outputs are compared against a sequential model of the program, so a wrong latency, a gap in the retire stream or a wrong destination index shows up in the cycle where it happens. A second program asserts reset while a store and a register write are in flight. If either write reaches state, that shows as a change in a memory word or a register.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  // control word produced by decode, held in the decode/execute register
  typedef struct packed {
    logic              valid;
    alu_op_e           alu_op;
    logic              use_imm;
    logic              mem_rd;
    logic              mem_wr;
    logic              reg_wr;
    logic [RIDX_W-1:0] wreg;
  } dec_ctl_t;

  // control bits still needed after execute
  typedef struct packed {
    logic              valid;
    logic              mem_rd;
    logic              mem_wr;
    logic              reg_wr;
    logic [RIDX_W-1:0] wreg;
  } mem_ctl_t;

  // control bits still needed in write-back
  typedef struct packed {
    logic              valid;
    logic              from_mem;
    logic              mem_ok;
    logic              reg_wr;
    logic [RIDX_W-1:0] wreg;
  } wb_ctl_t;
endpackage

// File: rtl/pipe5_fetch.sv
module pipe5_fetch #(
  parameter int IAW  = 6,
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            im_we,
  input  logic [IAW-1:0]  im_waddr,
  input  logic [XLEN-1:0] im_wdata,
  output logic            fd_valid,
  output logic [XLEN-1:0] fd_instr,
  output logic [XLEN-1:0] fd_pc4
);
  localparam int DEPTH = 1 << IAW;

  logic [XLEN-1:0] imem [DEPTH];
  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] pc_next;
  logic [IAW-1:0]  pc_idx;

  assign pc_next = pc + XLEN'(4);
  assign pc_idx  = pc[IAW+1:2];

  // block-RAM style: write port from the host, registered read at the PC
  always_ff @(posedge clk) begin
    if (im_we) imem[im_waddr] <= im_wdata;
    if (run)   fd_instr <= imem[pc_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      fd_valid <= 1'b0;
      fd_pc4   <= '0;
    end else begin
      fd_valid <= run;
      if (run) begin
        pc     <= pc_next;
        fd_pc4 <= pc_next;
      end
    end
  end
endmodule

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic              valid,
  input  logic [XLEN-1:0]   instr,
  output dec_ctl_t          ctl,
  output logic [RIDX_W-1:0] rs,
  output logic [RIDX_W-1:0] rt,
  output logic [XLEN-1:0]   imm
);
  logic [5:0] opcode;
  logic [5:0] funct;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign imm    = {{(XLEN-16){instr[15]}}, instr[15:0]};

  always_comb begin
    ctl       = '0;
    ctl.valid = valid;
    if (valid) begin
      case (opcode)
        OP_RTYPE: begin
          ctl.wreg = instr[15:11];
          case (funct)
            FN_ADD: begin ctl.alu_op = ALU_ADD; ctl.reg_wr = 1'b1; end
            FN_SUB: begin ctl.alu_op = ALU_SUB; ctl.reg_wr = 1'b1; end
            FN_AND: begin ctl.alu_op = ALU_AND; ctl.reg_wr = 1'b1; end
            FN_OR:  begin ctl.alu_op = ALU_OR;  ctl.reg_wr = 1'b1; end
            default: ctl.reg_wr = 1'b0;
          endcase
        end
        OP_LOAD: begin
          ctl.alu_op  = ALU_ADD;
          ctl.use_imm = 1'b1;
          ctl.mem_rd  = 1'b1;
          ctl.reg_wr  = 1'b1;
          ctl.wreg    = instr[20:16];
        end
        OP_STORE: begin
          ctl.alu_op  = ALU_ADD;
          ctl.use_imm = 1'b1;
          ctl.mem_wr  = 1'b1;
        end
        default: ctl.reg_wr = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [W-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  input  logic [$clog2(NREG)-1:0] ra3,
  output logic [W-1:0]            rd1,
  output logic [W-1:0]            rd2,
  output logic [W-1:0]            rd3_q
);
  localparam int AW = $clog2(NREG);

  logic [W-1:0] regs [NREG];
  logic         wr_live;

  assign wr_live = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_live) regs[waddr] <= wdata;
  end

  // decode ports see a same-cycle write through the bypass
  always_comb begin
    if (ra1 == AW'(0))                rd1 = '0;
    else if (wr_live && waddr == ra1) rd1 = wdata;
    else                              rd1 = regs[ra1];
    if (ra2 == AW'(0))                rd2 = '0;
    else if (wr_live && waddr == ra2) rd2 = wdata;
    else                              rd2 = regs[ra2];
  end

  // host read port, registered
  always_ff @(posedge clk) begin
    rd3_q <= (ra3 == AW'(0)) ? '0 : regs[ra3];
  end
endmodule

// File: rtl/pipe5_dmem.sv
module pipe5_dmem #(
  parameter int DAW = 6,
  parameter int W   = 32
) (
  input  logic           clk,
  input  logic           we,
  input  logic [DAW-1:0] addr,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   q
);
  localparam int DEPTH = 1 << DAW;

  logic [W-1:0] mem [DEPTH];

  // single-port, read-before-write block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IAW = 6,
  parameter int DAW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              im_we,
  input  logic [IAW-1:0]    im_waddr,
  input  logic [31:0]       im_wdata,
  input  logic              dm_we,
  input  logic [DAW-1:0]    dm_addr,
  input  logic [31:0]       dm_wdata,
  output logic [31:0]       dm_rdata,
  input  logic [4:0]        reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic              ret_valid,
  output logic              ret_we,
  output logic [4:0]        ret_idx,
  output logic [31:0]       ret_data,
  output logic [31:0]       ret_pc4
);
  localparam int NREG = 1 << RIDX_W;

  // ---------------- fetch ----------------
  logic            fd_valid;
  logic [XLEN-1:0] fd_instr;
  logic [XLEN-1:0] fd_pc4;

  pipe5_fetch #(.IAW(IAW), .XLEN(XLEN)) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .im_we    (im_we),
    .im_waddr (im_waddr),
    .im_wdata (im_wdata),
    .fd_valid (fd_valid),
    .fd_instr (fd_instr),
    .fd_pc4   (fd_pc4)
  );

  // ---------------- decode ----------------
  dec_ctl_t          id_ctl;
  logic [RIDX_W-1:0] id_rs;
  logic [RIDX_W-1:0] id_rt;
  logic [XLEN-1:0]   id_imm;
  logic [XLEN-1:0]   id_a;
  logic [XLEN-1:0]   id_b;

  pipe5_decode u_decode (
    .valid (fd_valid),
    .instr (fd_instr),
    .ctl   (id_ctl),
    .rs    (id_rs),
    .rt    (id_rt),
    .imm   (id_imm)
  );

  wb_ctl_t         mw_ctl;
  logic [XLEN-1:0] wb_data;
  logic            wb_we;

  pipe5_regfile #(.NREG(NREG), .W(XLEN)) u_regfile (
    .clk   (clk),
    .we    (wb_we),
    .waddr (mw_ctl.wreg),
    .wdata (wb_data),
    .ra1   (id_rs),
    .ra2   (id_rt),
    .ra3   (reg_raddr),
    .rd1   (id_a),
    .rd2   (id_b),
    .rd3_q (reg_rdata)
  );

  // decode/execute register
  dec_ctl_t        de_ctl;
  logic [XLEN-1:0] de_a, de_b, de_imm, de_pc4;

  always_ff @(posedge clk) begin
    if (rst) de_ctl <= '0;
    else     de_ctl <= id_ctl;
    de_a   <= id_a;
    de_b   <= id_b;
    de_imm <= id_imm;
    de_pc4 <= fd_pc4;
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] ex_opb;
  logic [XLEN-1:0] ex_res;

  assign ex_opb = de_ctl.use_imm ? de_imm : de_b;

  always_comb begin
    case (de_ctl.alu_op)
      ALU_ADD: ex_res = de_a + ex_opb;
      ALU_SUB: ex_res = de_a - ex_opb;
      ALU_AND: ex_res = de_a & ex_opb;
      ALU_OR:  ex_res = de_a | ex_opb;
      default: ex_res = '0;
    endcase
  end

  // execute/memory register
  mem_ctl_t        xm_ctl;
  logic [XLEN-1:0] xm_alu, xm_sdata, xm_pc4;

  always_ff @(posedge clk) begin
    if (rst) xm_ctl <= '0;
    else begin
      xm_ctl.valid  <= de_ctl.valid;
      xm_ctl.mem_rd <= de_ctl.mem_rd;
      xm_ctl.mem_wr <= de_ctl.mem_wr;
      xm_ctl.reg_wr <= de_ctl.reg_wr;
      xm_ctl.wreg   <= de_ctl.wreg;
    end
    xm_alu   <= ex_res;
    xm_sdata <= de_b;
    xm_pc4   <= de_pc4;
  end

  // ---------------- memory ----------------
  logic           xm_ok;
  logic           pipe_sel;
  logic           dmem_we;
  logic [DAW-1:0] dmem_addr;
  logic [31:0]    dmem_wdata;
  logic [31:0]    dmem_q;

  assign xm_ok = (xm_alu[1:0] == 2'b00) && (xm_alu[XLEN-1:DAW+2] == '0);

  // the pipeline owns the memory whenever its memory stage is occupied
  assign pipe_sel   = xm_ctl.valid;
  assign dmem_we    = pipe_sel ? (xm_ctl.mem_wr && xm_ok && !rst) : dm_we;
  assign dmem_addr  = pipe_sel ? xm_alu[DAW+1:2] : dm_addr;
  assign dmem_wdata = pipe_sel ? xm_sdata : dm_wdata;

  pipe5_dmem #(.DAW(DAW), .W(32)) u_dmem (
    .clk   (clk),
    .we    (dmem_we),
    .addr  (dmem_addr),
    .wdata (dmem_wdata),
    .q     (dmem_q)
  );

  assign dm_rdata = dmem_q;

  // memory/write-back register
  logic [XLEN-1:0] mw_alu, mw_pc4;

  always_ff @(posedge clk) begin
    if (rst) mw_ctl <= '0;
    else begin
      mw_ctl.valid    <= xm_ctl.valid;
      mw_ctl.from_mem <= xm_ctl.mem_rd;
      mw_ctl.mem_ok   <= xm_ok;
      mw_ctl.reg_wr   <= xm_ctl.reg_wr;
      mw_ctl.wreg     <= xm_ctl.wreg;
    end
    mw_alu <= xm_alu;
    mw_pc4 <= xm_pc4;
  end

  // ---------------- write-back ----------------
  always_comb begin
    if (mw_ctl.from_mem) wb_data = mw_ctl.mem_ok ? dmem_q : '0;
    else                 wb_data = mw_alu;
  end

  assign wb_we = mw_ctl.valid && mw_ctl.reg_wr && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid <= 1'b0;
      ret_we    <= 1'b0;
    end else begin
      ret_valid <= mw_ctl.valid;
      ret_we    <= mw_ctl.valid && mw_ctl.reg_wr;
    end
    ret_idx  <= mw_ctl.wreg;
    ret_data <= wb_data;
    ret_pc4  <= mw_pc4;
  end
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        run,
  input logic [4:0]  reg_raddr,
  input logic [31:0] reg_rdata,
  input logic        ret_valid,
  input logic [31:0] ret_pc4
);
  logic [4:0] run_hist;
  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_hist  <= '0;
      since_rst <= '0;
    end else begin
      run_hist <= {run_hist[3:0], run};
      if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end
  end

  AST_FILL_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> (since_rst >= 3'd5)); // R1

  AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (ret_valid == run_hist[4])); // R3

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && $past(ret_valid)) |-> (ret_pc4 == $past(ret_pc4) + 32'd4)); // R2

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
    (reg_raddr == 5'd0) |=> (reg_rdata == 32'd0)); // R7

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !ret_valid); // R9
endmodule

bind pipe5_core pipe5_core_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .reg_raddr (reg_raddr),
  .reg_rdata (reg_rdata),
  .ret_valid (ret_valid),
  .ret_pc4   (ret_pc4)
);

// File: tb/pipe5_core_bench.sv
module pipe5_core_bench;
  localparam int IAW = 6;
  localparam int DAW = 6;
  localparam int NW  = 64;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           run = 1'b0;
  logic           im_we = 1'b0;
  logic [IAW-1:0] im_waddr = '0;
  logic [31:0]    im_wdata = '0;
  logic           dm_we = 1'b0;
  logic [DAW-1:0] dm_addr = '0;
  logic [31:0]    dm_wdata = '0;
  logic [31:0]    dm_rdata;
  logic [4:0]     reg_raddr = '0;
  logic [31:0]    reg_rdata;
  logic           ret_valid, ret_we;
  logic [4:0]     ret_idx;
  logic [31:0]    ret_data, ret_pc4;

  pipe5_core #(.IAW(IAW), .DAW(DAW)) u_pipe5_core (
    .clk(clk), .rst(rst), .run(run),
    .im_we(im_we), .im_waddr(im_waddr), .im_wdata(im_wdata),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .ret_valid(ret_valid), .ret_we(ret_we), .ret_idx(ret_idx),
    .ret_data(ret_data), .ret_pc4(ret_pc4)
  );

  always #4 clk = ~clk;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  logic [31:0] prog  [NW];
  logic [31:0] m_rf  [32];
  logic [31:0] m_dm  [NW];
  logic        e_we  [NW];
  logic [4:0]  e_idx [NW];
  logic [31:0] e_dat [NW];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rd,
                                        input logic [4:0] rs, input logic [4:0] rt);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rt,
                                        input logic [4:0] rs, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // sequential reference model of the program, one slot per instruction
  task automatic model_run(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w, a, b, addr, res;
      logic        ok;
      w    = prog[i];
      a    = m_rf[w[25:21]];
      b    = m_rf[w[20:16]];
      addr = a + {{16{w[15]}}, w[15:0]};
      ok   = (addr[1:0] == 2'b00) && ((addr >> (DAW + 2)) == 32'd0);
      e_we[i] = 1'b0; e_idx[i] = 5'd0; e_dat[i] = 32'd0;
      if (w[31:26] == 6'h00 && (w[5:0] == 6'h20 || w[5:0] == 6'h22 ||
                                w[5:0] == 6'h24 || w[5:0] == 6'h25)) begin
        case (w[5:0])
          6'h20:   res = a + b;
          6'h22:   res = a - b;
          6'h24:   res = a & b;
          default: res = a | b;
        endcase
        e_we[i] = 1'b1; e_idx[i] = w[15:11]; e_dat[i] = res;
        if (w[15:11] != 5'd0) m_rf[w[15:11]] = res;
      end else if (w[31:26] == 6'h23) begin
        res = ok ? m_dm[addr[DAW+1:2]] : 32'd0;
        e_we[i] = 1'b1; e_idx[i] = w[20:16]; e_dat[i] = res;
        if (w[20:16] != 5'd0) m_rf[w[20:16]] = res;
      end else if (w[31:26] == 6'h2B) begin
        if (ok) m_dm[addr[DAW+1:2]] = b;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; run = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_imem();
    for (int i = 0; i < NW; i++) begin
      @(negedge clk); im_we = 1'b1; im_waddr = IAW'(i); im_wdata = prog[i];
    end
    @(negedge clk); im_we = 1'b0;
  endtask

  task automatic write_dm(input int idx, input logic [31:0] val);
    @(negedge clk); dm_we = 1'b1; dm_addr = DAW'(idx); dm_wdata = val;
    @(negedge clk); dm_we = 1'b0;
  endtask

  task automatic read_dm(input int idx, output logic [31:0] val);
    @(negedge clk); dm_we = 1'b0; dm_addr = DAW'(idx);
    @(negedge clk); val = dm_rdata;
  endtask

  task automatic read_reg(input int idx, output logic [31:0] val);
    @(negedge clk); reg_raddr = 5'(idx);
    @(negedge clk); val = reg_rdata;
  endtask

  // run for n fetch edges, checking the retire stream every cycle (R1 R2 R3)
  task automatic run_and_watch(input int n);
    @(negedge clk); run = 1'b1;
    for (int k = 1; k <= n + 6; k++) begin
      logic exp_v;
      int   slot;
      @(negedge clk);
      exp_v = (k >= 5) && (k <= n + 4);
      slot  = k - 5;
      if (k == 5) check("R1", "first retire at edge 5", 32'(ret_valid), 32'd1);
      else        check("R3", $sformatf("retire valid edge %0d", k), 32'(ret_valid), 32'(exp_v));
      if (exp_v && ret_valid) begin
        check("R2", $sformatf("pc4 slot %0d", slot), ret_pc4, 32'(4 * (slot + 1)));
        check("R4", $sformatf("we slot %0d", slot), 32'(ret_we), 32'(e_we[slot]));
        if (e_we[slot]) begin
          check("R5", $sformatf("idx slot %0d", slot), 32'(ret_idx), 32'(e_idx[slot]));
          check("R8", $sformatf("data slot %0d", slot), ret_data, e_dat[slot]);
        end
      end
      if (k == n) run = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    @(negedge clk);
    check("R9", "ret_valid after reset", 32'(ret_valid), 32'd0);
    check("R9", "ret_we after reset", 32'(ret_we), 32'd0);
    read_reg(0, v);
    check("R7", "r0 after reset", v, 32'd0);
  endtask

  task automatic t_mix_program();
    logic [31:0] v;
    for (int i = 0; i < NW; i++) begin
      prog[i] = 32'd0;
      m_dm[i] = 32'h5A00_0000 | 32'(i * 257);
    end
    m_dm[0] = 32'h1234_5678; m_dm[1] = 32'h0F0F_00FF; m_dm[2] = 32'h8000_0001;
    m_dm[3] = 32'h00FF_FF00; m_dm[4] = 32'd128;
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    prog[0]  = enc_i(6'h23, 5'd1, 5'd0, 16'd0);        // R5
    prog[1]  = enc_i(6'h23, 5'd2, 5'd0, 16'd4);
    prog[2]  = enc_i(6'h23, 5'd3, 5'd0, 16'd8);
    prog[3]  = enc_i(6'h23, 5'd4, 5'd0, 16'd12);
    prog[4]  = enc_i(6'h23, 5'd10, 5'd0, 16'd16);
    prog[5]  = enc_r(6'h20, 5'd5, 5'd1, 5'd2);          // R4 add
    prog[6]  = enc_r(6'h22, 5'd6, 5'd3, 5'd1);          // R4 sub
    prog[7]  = enc_r(6'h24, 5'd7, 5'd4, 5'd2);          // R4 and
    prog[8]  = enc_r(6'h25, 5'd8, 5'd1, 5'd10);         // R4 or
    prog[9]  = enc_i(6'h2B, 5'd5, 5'd10, 16'hFF9C);     // R6 negative offset
    prog[10] = enc_i(6'h2B, 5'd6, 5'd0, 16'd32);
    prog[11] = enc_r(6'h20, 5'd0, 5'd1, 5'd2);          // R7
    prog[12] = enc_i(6'h23, 5'd9, 5'd10, 16'hFFA0);
    prog[13] = enc_i(6'h2B, 5'd7, 5'd0, 16'd300);       // R10 beyond memory
    prog[14] = enc_i(6'h23, 5'd11, 5'd0, 16'd2);        // R10 misaligned
    prog[15] = enc_r(6'h22, 5'd12, 5'd8, 5'd3);
    prog[16] = enc_r(6'h24, 5'd13, 5'd9, 5'd1);
    prog[17] = 32'd0;                                   // R11 no-op
    prog[18] = enc_r(6'h25, 5'd14, 5'd12, 5'd7);        // R8 three slots behind
    do_reset();
    load_imem();                                        // R12
    for (int i = 0; i < NW; i++) write_dm(i, m_dm[i]);
    model_run(19);
    run_and_watch(19);
    for (int r = 0; r <= 14; r++) begin
      read_reg(r, v);
      check(r == 0 ? "R7" : "R12", $sformatf("register %0d", r), v, m_rf[r]);
    end
    for (int i = 0; i < NW; i++) begin
      read_dm(i, v);
      check(i == 11 ? "R10" : "R6", $sformatf("data word %0d", i), v, m_dm[i]);
    end
  endtask

  task automatic t_reset_mid_flight();
    logic [31:0] v;
    for (int i = 0; i < NW; i++) prog[i] = 32'd0;
    prog[0] = enc_i(6'h2B, 5'd5, 5'd0, 16'd36);   // store to word 9
    prog[1] = enc_r(6'h24, 5'd14, 5'd0, 5'd0);    // would clear r14
    do_reset();
    load_imem();
    write_dm(9, 32'hDEAD_BEEF);
    @(negedge clk); run = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b1; run = 1'b0;                       // R9: reset over edges 4 and 5
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R9", $sformatf("no retire after flush %0d", k), 32'(ret_valid), 32'd0);
    end
    read_dm(9, v);
    check("R9", "flushed store left memory alone", v, 32'hDEAD_BEEF);
    read_reg(14, v);
    check("R9", "flushed write left r14 alone", v, m_rf[14]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mix_program();
    t_reset_mid_flight();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule